// File: doc/BRIEF.md
# Time-Slotted Video SRAM Access Sequencer

This block lets one asynchronous SRAM serve two users, a display refresh path and a host write path, without any arbitration. The three low bits of the external horizontal pixel counter name one of eight fixed access slots, and the same pattern repeats every eight pixels. The first half of each group is for display reads. Slots 0, 1 and 2 each fetch one byte for the next column group: a pattern byte, a mask byte and an invert byte. Slot 3 is a guard slot that starts no read. The second half, which is the four slots where counter bit 2 is set, belongs to the host. In that half the latched host address and data drive the SRAM buses.

A host write is a single request: an address and a data byte presented with a valid strobe. It is latched while the host is not busy. The write strobe is pulsed only in slot 5, which lies inside the host window. The first and last slots of the window are therefore never written, and they act as setup and hold guard time. The three fetched bytes are combined into one pixel byte. That byte is loaded into a shift register at the group boundary and sent out one bit per pixel clock during the following group. The output reads 0 while blanking is asserted.

Top module: `vram_slot_sequencer`

## Requirements
- R1: The slot index is the low 3 bits of `hcnt`. `sram_oe_n` is low in slots 0, 1 and 2 and high in slots 3 to 7.
- R2: In slots 0 to 3, `sram_addr` = {slot[1:0], `row`, column+1}, where column is `hcnt[8:3]` and the sum is taken modulo 64. Plane 0 is the pattern, plane 1 the mask and plane 2 the invert byte.
- R3: In slots 4 to 7, `sram_dq_oe` is high, and `sram_addr`/`sram_dq_o` hold the most recently accepted host address and data, unchanged across the window. In slots 0 to 3, `sram_dq_oe` is low.
- R4: `sram_we_n` goes low only in slot 5, and only when a host write is pending. It is never low in slots 4, 6 or 7, and never low together with `sram_oe_n`.
- R5: Each accepted request produces exactly one write pulse, and the pending state clears at the end of that slot 5.
- R6: `host_busy` is high while a write is pending or while the slot is 4 to 7. A request presented while `host_busy` is high is ignored and does not change the latched address or data.
- R7: `sram_ce_n` is low at all times.
- R8: The pixel byte is (pattern AND mask) XOR invert, using the three bytes fetched in a group. It appears on `pixel_out` during the next group, MSB first, with bit 7−slot shown in each slot.
- R9: While `blank` is high, `pixel_out` is 0.
- R10: In reset, `sram_we_n` is high, no write is pending and the shift register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hcnt | input | 9 | Horizontal pixel counter |
| row | input | 5 | Character row used in display addresses |
| blank | input | 1 | Blanking, forces pixel output low |
| host_wr_valid | input | 1 | Host write request strobe |
| host_wr_addr | input | 13 | Host write address |
| host_wr_data | input | 8 | Host write data |
| host_busy | output | 1 | Request would be ignored this cycle |
| sram_addr | output | 13 | SRAM address, always driven |
| sram_dq_o | output | 8 | Data toward SRAM |
| sram_dq_oe | output | 1 | Data bus drive enable |
| sram_dq_i | input | 8 | Data from SRAM |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| pixel_out | output | 1 | Serial pixel |

## Verification
The hardest case to reach is a request that arrives while an earlier write is still pending. It must be dropped even though `host_busy` falls a few cycles later. The driver creates this case by presenting a different address and data on every cycle that `host_busy` reads high right after an acceptance. It stops the moment busy drops. The scoreboard then requires that the only write pulse carries the first request. Pixel checks follow writes into the mask and invert planes of rows that are displayed later, so fetched bytes are compared after the SRAM contents have changed.

// File: rtl/vss_pkg.sv
package vss_pkg;
  localparam int SLOT_W    = 3;
  localparam int PLANE_W   = 2;
  localparam int RD_SLOTS  = 3;
  localparam int WR_SLOT   = 5;

  typedef struct packed {
    logic               rd;
    logic [PLANE_W-1:0] plane;
    logic               host_win;
    logic               wr_slot;
    logic               grp_end;
  } slot_ctl_t;
endpackage

// File: rtl/vss_slot_decode.sv
module vss_slot_decode
  import vss_pkg::*;
(
  input  logic [SLOT_W-1:0] slot,
  output slot_ctl_t         ctl
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'((1 << SLOT_W) - 1);

  always_comb begin
    ctl.plane    = slot[PLANE_W-1:0];
    ctl.host_win = slot[SLOT_W-1];
    ctl.rd       = (slot < SLOT_W'(RD_SLOTS));
    ctl.wr_slot  = (slot == SLOT_W'(WR_SLOT));
    ctl.grp_end  = (slot == LAST);
  end
endmodule

// File: rtl/vss_host_latch.sv
module vss_host_latch #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_window,
  input  logic              wr_slot,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic              pend,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [DATA_W-1:0] lat_data
);
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              accept;

  assign busy   = pend_q | in_window;
  assign accept = req_valid & ~busy;

  always_comb begin
    pend_d = pend_q;
    addr_d = addr_q;
    data_d = data_q;
    if (accept) begin
      pend_d = 1'b1;
      addr_d = req_addr;
      data_d = req_data;
    end else if (wr_slot && pend_q) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (accept) begin
        addr_q <= addr_d;
        data_q <= data_d;
      end
    end
  end

  assign pend     = pend_q;
  assign lat_addr = addr_q;
  assign lat_data = data_q;
endmodule

// File: rtl/vss_pixel_path.sv
module vss_pixel_path
  import vss_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [PLANE_W-1:0] plane,
  input  logic               grp_end,
  input  logic [DATA_W-1:0]  rd_data,
  input  logic               blank,
  output logic               pixel
);
  logic [DATA_W-1:0] fetch_q [RD_SLOTS];
  logic [DATA_W-1:0] shift_q, shift_d;
  logic [DATA_W-1:0] pix_byte;

  for (genvar i = 0; i < RD_SLOTS; i++) begin : g_fetch
    logic cap_en;
    assign cap_en = rd_en && (plane == PLANE_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fetch_q[i] <= '0;
      else if (cap_en) fetch_q[i] <= rd_data;
    end
  end

  // plane 0 pattern, plane 1 mask, plane 2 invert
  assign pix_byte = (fetch_q[0] & fetch_q[1]) ^ fetch_q[2];

  always_comb begin
    if (grp_end) shift_d = pix_byte;
    else         shift_d = {shift_q[DATA_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign pixel = ~blank & shift_q[DATA_W-1];
endmodule

// File: rtl/vram_slot_sequencer.sv
module vram_slot_sequencer
  import vss_pkg::*;
#(
  parameter  int HCNT_W = 9,
  parameter  int ROW_W  = 5,
  parameter  int DATA_W = 8,
  localparam int COL_W  = HCNT_W - SLOT_W,
  localparam int ADDR_W = PLANE_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HCNT_W-1:0] hcnt,
  input  logic [ROW_W-1:0]  row,
  input  logic              blank,
  input  logic              host_wr_valid,
  input  logic [ADDR_W-1:0] host_wr_addr,
  input  logic [DATA_W-1:0] host_wr_data,
  output logic              host_busy,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic              pixel_out
);
  slot_ctl_t         ctl;
  logic              pend;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_data;
  logic [COL_W-1:0]  col_next;
  logic [ADDR_W-1:0] disp_addr;

  vss_slot_decode u_dec (
    .slot (hcnt[SLOT_W-1:0]),
    .ctl  (ctl)
  );

  vss_host_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_host (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_window (ctl.host_win),
    .wr_slot   (ctl.wr_slot),
    .req_valid (host_wr_valid),
    .req_addr  (host_wr_addr),
    .req_data  (host_wr_data),
    .busy      (host_busy),
    .pend      (pend),
    .lat_addr  (lat_addr),
    .lat_data  (lat_data)
  );

  vss_pixel_path #(.DATA_W(DATA_W)) u_pix (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (ctl.rd),
    .plane   (ctl.plane),
    .grp_end (ctl.grp_end),
    .rd_data (sram_dq_i),
    .blank   (blank),
    .pixel   (pixel_out)
  );

  // fetches in this group feed the following column group
  assign col_next  = hcnt[HCNT_W-1:SLOT_W] + COL_W'(1);
  assign disp_addr = {ctl.plane, row, col_next};

  assign sram_addr  = ctl.host_win ? lat_addr : disp_addr;
  assign sram_dq_o  = lat_data;
  assign sram_dq_oe = ctl.host_win;
  assign sram_ce_n  = 1'b0;
  assign sram_oe_n  = ~ctl.rd;
  assign sram_we_n  = ~(ctl.wr_slot & pend);
endmodule

// File: rtl/vram_slot_sequencer_chk.sv
module vram_slot_sequencer_chk #(
  parameter int HCNT_W = 9,
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [HCNT_W-1:0] hcnt,
  input logic              blank,
  input logic              host_wr_valid,
  input logic              host_busy,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [DATA_W-1:0] sram_dq_o,
  input logic              sram_dq_oe,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic              pixel_out
);
  AST_READ_SLOTS_ONLY: assert property (@(posedge clk) disable iff (!rst_n) !sram_oe_n |-> (hcnt[2:0] < 3'd3)); // R1
  AST_NO_READ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) sram_dq_oe |-> sram_oe_n); // R3
  AST_WINDOW_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (sram_dq_oe && $past(sram_dq_oe)) |-> ($stable(sram_addr) && $stable(sram_dq_o))); // R3
  AST_WE_MID_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) !sram_we_n |-> (hcnt[2:0] == 3'd5 && sram_dq_oe)); // R4
  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!sram_oe_n && !sram_we_n)); // R4
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) !sram_we_n |=> sram_we_n); // R5
  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (host_wr_valid && !host_busy) |=> host_busy); // R6
  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n) blank |-> !pixel_out); // R9
endmodule

bind vram_slot_sequencer vram_slot_sequencer_chk #(
  .HCNT_W(HCNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .blank(blank),
  .host_wr_valid(host_wr_valid), .host_busy(host_busy),
  .sram_addr(sram_addr), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
  .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .pixel_out(pixel_out)
);

// File: tb/vram_slot_sequencer_tb.sv
`timescale 1ns/1ps
module vram_slot_sequencer_tb;
  localparam int CLK_PERIOD = 80;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [8:0]  hcnt;
  logic [4:0]  row;
  logic        blank;
  logic        host_wr_valid;
  logic [12:0] host_wr_addr;
  logic [7:0]  host_wr_data;
  logic        host_busy;
  logic [12:0] sram_addr;
  logic [7:0]  sram_dq_o;
  logic        sram_dq_oe;
  logic [7:0]  sram_dq_i;
  logic        sram_ce_n, sram_oe_n, sram_we_n, pixel_out;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0]  mem [int];
  logic [20:0] wq [$];
  logic [7:0]  pq [$];
  logic [12:0] exp_lat_addr = '0;
  logic [7:0]  exp_lat_data = '0;
  logic [7:0]  cur_byte = '0;
  bit          have_byte = 1'b0;
  bit          monitor_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vram_slot_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .row(row), .blank(blank),
    .host_wr_valid(host_wr_valid), .host_wr_addr(host_wr_addr),
    .host_wr_data(host_wr_data), .host_busy(host_busy),
    .sram_addr(sram_addr), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
    .sram_dq_i(sram_dq_i), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .pixel_out(pixel_out)
  );

  // pixel counter and row source
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      row  <= '0;
    end else begin
      hcnt <= hcnt + 9'd1;
      if (hcnt == 9'd511) row <= row + 5'd1;
    end
  end

  function automatic logic [7:0] mem_rd(logic [12:0] a);
    logic [15:0] t;
    if (mem.exists(int'(a))) return mem[int'(a)];
    t = {3'b0, a} * 16'd29 + {11'b0, a[12:8]};
    return t[7:0];
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // SRAM write at the edge closing a strobed slot
  always @(posedge clk) begin
    if (rst_n && !sram_we_n) mem[int'(sram_addr)] = sram_dq_o;
  end

  // monitor and SRAM read model, away from the active edge
  always @(negedge clk) begin
    logic [2:0]  s;
    logic [5:0]  cn;
    logic [12:0] ea;
    logic [20:0] w;
    logic [7:0]  b;
    sram_dq_i = sram_oe_n ? 8'h00 : mem_rd(sram_addr);
    if (rst_n && monitor_on) begin
      s  = hcnt[2:0];
      cn = hcnt[8:3] + 6'd1;
      chk(sram_ce_n == 1'b0, "R7", "ce_n", int'(sram_ce_n), 0);
      chk(sram_oe_n == (s >= 3'd3), "R1", "oe_n", int'(sram_oe_n), int'(s >= 3'd3));
      if (s < 3'd4) begin
        ea = {s[1:0], row, cn};
        chk(sram_addr == ea, "R2", "display addr", int'(sram_addr), int'(ea));
        chk(!sram_dq_oe, "R3", "dq_oe outside window", int'(sram_dq_oe), 0);
      end else begin
        chk(sram_dq_oe && sram_addr == exp_lat_addr && sram_dq_o == exp_lat_data,
            "R3", "host window addr", int'(sram_addr), int'(exp_lat_addr));
      end
      if (!sram_we_n) begin
        chk(s == 3'd5, "R4", "write slot", int'(s), 5);
        if (wq.size() == 0) begin
          chk(1'b0, "R5", "unexpected write", int'(sram_addr), 0);
        end else begin
          w = wq.pop_front();
          chk({sram_addr, sram_dq_o} == w, "R6", "write item", int'({sram_addr, sram_dq_o}), int'(w));
        end
      end
      if (s == 3'd0) begin
        have_byte = (pq.size() != 0);
        if (have_byte) cur_byte = pq.pop_front();
      end
      if (have_byte) begin
        b = blank ? 8'h00 : cur_byte;
        chk(pixel_out == b[3'd7 - s], blank ? "R9" : "R8", "pixel",
            int'(pixel_out), int'(b[3'd7 - s]));
      end
      if (s == 3'd2) begin
        b = (mem_rd({2'd0, row, cn}) & mem_rd({2'd1, row, cn})) ^ mem_rd({2'd2, row, cn});
        pq.push_back(b);
      end
    end
  end

  task automatic host_write(logic [12:0] a, logic [7:0] d);
    @(negedge clk);
    while (host_busy) @(negedge clk);
    host_wr_valid = 1'b1;
    host_wr_addr  = a;
    host_wr_data  = d;
    @(posedge clk);
    exp_lat_addr = a;
    exp_lat_data = d;
    wq.push_back({a, d});
    @(negedge clk);
    host_wr_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    rst_n = 1'b0;
    blank = 1'b0;
    host_wr_valid = 1'b0;
    host_wr_addr = '0;
    host_wr_data = '0;
    sram_dq_i = '0;
    repeat (3) @(negedge clk);
    // reset state, R10
    chk(sram_we_n == 1'b1, "R10", "we_n in reset", int'(sram_we_n), 1);
    chk(host_busy == 1'b0, "R10", "busy in reset", int'(host_busy), 0);
    chk(pixel_out == 1'b0, "R10", "pixel in reset", int'(pixel_out), 0);
    @(posedge clk);
    rst_n <= 1'b1;
    monitor_on = 1'b1;
    repeat (520) @(posedge clk);

    // writes into rows shown later (row 2 and 3), all three planes
    for (int i = 0; i < 12; i++) begin
      host_write({2'(i % 3), 5'd2 + 5'(i / 6), 6'(i * 5)}, 8'(8'h35 * i + 8'h0F));
    end
    host_write({2'd1, 5'd3, 6'd0}, 8'hF0);
    host_write({2'd2, 5'd3, 6'd0}, 8'h3C);

    // request while busy must be ignored, R6
    host_write(13'h1ABC, 8'hA5);
    forever begin
      @(negedge clk);
      if (!host_busy) break;
      host_wr_valid = 1'b1;
      host_wr_addr  = 13'h0555;
      host_wr_data  = 8'h5A;
    end
    host_wr_valid = 1'b0;
    repeat (16) @(negedge clk);
    chk(wq.size() == 0, "R6", "ignored request left queue", wq.size(), 0);
    chk(sram_addr != 13'h0555 || !sram_dq_oe, "R6", "latch unchanged", int'(sram_addr), 13'h1ABC);

    // blanking across a few groups, R9
    @(posedge clk);
    blank <= 1'b1;
    repeat (37) @(posedge clk);
    blank <= 1'b0;

    // let rows 2 and 3 be displayed, including the column wrap
    while (!(row == 5'd4 && hcnt == 9'd100)) @(posedge clk);
    @(negedge clk);
    chk(wq.size() == 0, "R5", "all writes done once", wq.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule